// File: doc/BRIEF.md
# Page Write and Protection Controller

This block sits between a two-wire serial slave's protocol engine and its nonvolatile byte array. The protocol engine hands it a 12-bit start address and a stream of received data bytes. The address splits into a 7-bit page number (bits 11..5) and a 5-bit byte offset (bits 4..0). Each byte goes into a 32-entry page latch at the current offset. The offset then advances and wraps inside the page, so the page number never changes during a load.

When the protocol engine reports a stop condition, the controller commits every latch entry that received data to the array. It does this with one write strobe per entry, during a self-timed cycle. Busy is raised for a fixed number of system-clock cycles, and while busy is high every input from the bus side is ignored. A write-protect input guards the upper quarter of the array, which is the pages with address bits 11..10 equal to 2'b11. A stop that finds the write-protect input high and the loaded page in that region discards the latch. Such a stop writes nothing and raises no busy. A stop with no data loaded, as happens after a dummy write that only sets the address, also starts no cycle.

Top module: `pw_ctrl`

## Requirements
- R1: While reset is asserted and right after it, busy is 0, arr_we is 0 and cur_addr is 0.
- R2: In idle, an addr_load pulse sets cur_addr to addr_in and empties the page latch.
- R3: In idle, each byte_valid pulse stores byte_in at offset cur_addr[4:0] and increments that offset modulo 32. cur_addr[11:5] is unchanged.
- R4: If more than 32 bytes are loaded, a later byte replaces the earlier one held at the same wrapped offset. Only the last value for each offset reaches the array.
- R5: A stop with at least one byte loaded and no protection writes exactly the loaded offsets of the current page. Each such location {page, offset} gets its latched byte, and every other array location is left unchanged. All arr_we pulses fall while busy is 1.
- R6: For a committing stop pulse, busy rises in the cycle after the pulse and stays high for exactly WRITE_CYCLES clock cycles. Values of WRITE_CYCLES below 33 are raised to 33.
- R7: A stop with an empty latch produces no arr_we and leaves busy at 0.
- R8: If wp is 1 at the stop and cur_addr[11:10] is 2'b11, nothing is written and busy stays 0. The latch is discarded, so a following stop also commits nothing.
- R9: With wp at 0, pages in the upper quarter are written like any other page.
- R10: While busy is 1, addr_load, byte_valid and stop_evt have no effect. When busy falls, cur_addr holds its value from the stop, and none of the bytes presented during busy reach the array.
- R11: With wp at 1, pages with cur_addr[11:10] other than 2'b11 are still written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Pulse: take addr_in as the new page and offset |
| addr_in | input | 12 | Start address from the protocol engine |
| byte_valid | input | 1 | Pulse: one received data byte on byte_in |
| byte_in | input | 8 | Received data byte |
| stop_evt | input | 1 | Pulse: stop condition seen on the bus |
| wp | input | 1 | Write-protect input for the upper quarter |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 12 | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| cur_addr | output | 12 | Updated address for the address counter |

## Verification
The bench loads starting offsets near the end of a page and sends up to 40 bytes. A design that carries the wrap into the page number, or that writes stale latch entries, then damages a neighbouring page or the untouched offsets, and the full-array comparison catches both. Protected stops in the upper quarter are each followed by a second stop. Leaking the discarded latch into the next cycle would show up there as an unexpected busy window. The bench also drives address, data and stop pulses in the middle of busy. It then checks that the address and the array still match the values from before the commit, which catches a controller that listens to the bus during the write cycle. The busy length is counted cycle by cycle against WRITE_CYCLES, and an off-by-one in the timer shows up directly.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PROG = 2'd1,
        ST_HOLD = 2'd2
    } pw_state_e;
endpackage

// File: rtl/pw_latch.sv
module pw_latch #(
    parameter int OFF_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    localparam int SLOTS = 1 << OFF_W;

    logic [SLOTS-1:0]  vld_vec;
    logic [DATA_W-1:0] dat_arr [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        typedef struct packed {
            logic              vld;
            logic [DATA_W-1:0] dat;
        } slot_t;

        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr) begin
                slot_d.vld = 1'b0;
            end else if (wr_en && (wr_off == OFF_W'(i))) begin
                slot_d.vld = 1'b1;
                slot_d.dat = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign vld_vec[i] = slot_q.vld;
        assign dat_arr[i] = slot_q.dat;
    end

    assign rd_data   = dat_arr[rd_off];
    assign rd_valid  = vld_vec[rd_off];
    assign any_valid = |vld_vec;

    AST_CLR_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && wr_en)); // R3

    AST_WR_MARKS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> any_valid); // R3
endmodule

// File: rtl/pw_timer.sv
module pw_timer #(
    parameter int CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = CW'(CYCLES - 1);
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign active = tmr_q.run;
    assign done   = tmr_q.run && (tmr_q.cnt == '0);

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active); // R6

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !active); // R6
endmodule

// File: rtl/pw_guard.sv
module pw_guard #(
    parameter int ADDR_W = 12,
    parameter int PROT_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wp,
    output logic              blocked
);
    logic in_region;

    always_comb begin
        in_region = &addr[ADDR_W-1 -: PROT_W];
        blocked   = wp && in_region;
    end
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl #(
    parameter int ADDR_W       = 12,
    parameter int OFF_W        = 5,
    parameter int DATA_W       = 8,
    parameter int PROT_W       = 2,
    parameter int WRITE_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              stop_evt,
    input  logic              wp,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr
);
    import pw_pkg::*;

    localparam int PAGE_W      = ADDR_W - OFF_W;
    localparam int PAGE_BYTES  = 1 << OFF_W;
    localparam int HOLD_CYCLES = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES + 1;
    localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(PAGE_BYTES - 1);

    typedef struct packed {
        pw_state_e         st;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
        logic [OFF_W-1:0]  scan;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              lat_clr;
    logic              lat_wr;
    logic [DATA_W-1:0] lat_rd_data;
    logic              lat_rd_valid;
    logic              lat_any;
    logic              tmr_start;
    logic              tmr_active;
    logic              tmr_done;
    logic              prot_blocked;

    pw_latch #(
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (lat_clr),
        .wr_en     (lat_wr),
        .wr_off    (ctl_q.off),
        .wr_data   (byte_in),
        .rd_off    (ctl_q.scan),
        .rd_data   (lat_rd_data),
        .rd_valid  (lat_rd_valid),
        .any_valid (lat_any)
    );

    pw_timer #(
        .CYCLES (HOLD_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .active (tmr_active),
        .done   (tmr_done)
    );

    pw_guard #(
        .ADDR_W (ADDR_W),
        .PROT_W (PROT_W)
    ) u_guard (
        .addr    (cur_addr),
        .wp      (wp),
        .blocked (prot_blocked)
    );

    always_comb begin
        ctl_d     = ctl_q;
        lat_clr   = 1'b0;
        lat_wr    = 1'b0;
        tmr_start = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (stop_evt) begin
                    if (lat_any && !prot_blocked) begin
                        ctl_d.st   = ST_PROG;
                        ctl_d.scan = '0;
                        tmr_start  = 1'b1;
                    end else begin
                        lat_clr = 1'b1;
                    end
                end else if (addr_load) begin
                    ctl_d.page = addr_in[ADDR_W-1:OFF_W];
                    ctl_d.off  = addr_in[OFF_W-1:0];
                    lat_clr    = 1'b1;
                end else if (byte_valid) begin
                    lat_wr    = 1'b1;
                    ctl_d.off = ctl_q.off + 1'b1;
                end
            end
            ST_PROG: begin
                ctl_d.scan = ctl_q.scan + 1'b1;
                if (ctl_q.scan == OFF_MAX) begin
                    ctl_d.st = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    ctl_d.st = ST_IDLE;
                    lat_clr  = 1'b1;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, page: '0, off: '0, scan: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = (ctl_q.st != ST_IDLE);
    assign arr_we    = (ctl_q.st == ST_PROG) && lat_rd_valid;
    assign arr_addr  = {ctl_q.page, ctl_q.scan};
    assign arr_wdata = lat_rd_data;
    assign cur_addr  = {ctl_q.page, ctl_q.off};

    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R5

    AST_BUSY_MATCH_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        busy == tmr_active); // R6

    AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_evt && !lat_any) |=> !busy); // R7

    AST_PROT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_evt && wp && (&cur_addr[ADDR_W-1 -: PROT_W])) |=> !busy); // R8

    AST_BUSY_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(cur_addr))); // R10

    AST_OFF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !stop_evt && !addr_load && byte_valid && (cur_addr[OFF_W-1:0] == OFF_MAX))
        |=> ((cur_addr[OFF_W-1:0] == '0) && $stable(cur_addr[ADDR_W-1:OFF_W]))); // R3
endmodule

// File: tb/sim_pw_ctrl.sv
module sim_pw_ctrl;
    localparam int WC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_load = 1'b0;
    logic [11:0] addr_in = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        stop_evt = 1'b0;
    logic        wp = 1'b0;
    logic        arr_we;
    logic [11:0] arr_addr;
    logic [7:0]  arr_wdata;
    logic        busy;
    logic [11:0] cur_addr;

    int compared = 0;
    int mismatched = 0;

    logic [7:0]  dut_mem [4096];
    logic [7:0]  ref_mem [4096];
    logic [6:0]  m_pg = '0;
    logic [4:0]  m_off = '0;
    logic [31:0] m_v = '0;
    logic [7:0]  m_lat [32];

    pw_ctrl #(.WRITE_CYCLES(WC)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_load  (addr_load),
        .addr_in    (addr_in),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .stop_evt   (stop_evt),
        .wp         (wp),
        .arr_we     (arr_we),
        .arr_addr   (arr_addr),
        .arr_wdata  (arr_wdata),
        .busy       (busy),
        .cur_addr   (cur_addr)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) dut_mem[i] <= 8'h00;
        end else if (arr_we) begin
            dut_mem[arr_addr] <= arr_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_load(input logic [11:0] a);
        @(negedge clk);
        addr_load = 1'b1;
        addr_in   = a;
        @(negedge clk);
        addr_load = 1'b0;
        m_pg  = a[11:5];
        m_off = a[4:0];
        m_v   = '0;
        chk(cur_addr == {m_pg, m_off}, "R2", "cur_addr after load",
            int'(cur_addr), int'({m_pg, m_off}));
    endtask

    task automatic t_byte(input logic [7:0] d, input string req);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = d;
        @(negedge clk);
        byte_valid = 1'b0;
        m_lat[m_off] = d;
        m_v[m_off]   = 1'b1;
        m_off        = m_off + 5'd1;
        chk(cur_addr == {m_pg, m_off}, req, "cur_addr after byte",
            int'(cur_addr), int'({m_pg, m_off}));
    endtask

    task automatic t_stop(input bit poke, input string req);
        logic [11:0] saved;
        bit commit;
        int n;
        int bad;
        saved  = {m_pg, m_off};
        commit = (m_v != '0) && !(wp && (m_pg[6:5] == 2'b11));
        @(negedge clk);
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
        n = 0;
        while (busy && n < 1000) begin
            n++;
            if (poke && n >= 2 && n <= 4) begin
                addr_load  = 1'b1;
                addr_in    = 12'($urandom);
                byte_valid = 1'b1;
                byte_in    = 8'($urandom);
                stop_evt   = 1'b1;
            end else begin
                addr_load  = 1'b0;
                byte_valid = 1'b0;
                stop_evt   = 1'b0;
            end
            @(negedge clk);
        end
        addr_load  = 1'b0;
        byte_valid = 1'b0;
        stop_evt   = 1'b0;
        chk(n == (commit ? WC : 0), commit ? "R6" : req, "busy cycles", n, commit ? WC : 0);
        if (commit) begin
            for (int i = 0; i < 32; i++) begin
                if (m_v[i]) ref_mem[{m_pg, 5'(i)}] = m_lat[i];
            end
        end
        m_v = '0;
        chk(cur_addr == saved, poke ? "R10" : req, "cur_addr after stop",
            int'(cur_addr), int'(saved));
        bad = 0;
        for (int i = 0; i < 4096; i++) begin
            if (dut_mem[i] !== ref_mem[i]) bad++;
        end
        chk(bad == 0, req, "array locations differing", bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) ref_mem[i] = 8'h00;
        for (int i = 0; i < 32; i++) m_lat[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!busy && !arr_we && cur_addr == 12'h000, "R1", "state in reset",
            int'({busy, arr_we, cur_addr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !arr_we && cur_addr == 12'h000, "R1", "state after reset",
            int'({busy, arr_we, cur_addr}), 0);

        // single byte write
        wp = 1'b0;
        t_load(12'h123);
        t_byte(8'hAA, "R3");
        t_stop(1'b0, "R5");

        // offset wrap and overwrite: start at offset 30, 35 bytes
        t_load(12'h05E);
        for (int i = 0; i < 35; i++) t_byte(8'(8'h40 + i), "R3");
        t_stop(1'b0, "R4");

        // address only, no data
        t_load(12'h200);
        t_stop(1'b0, "R7");
        t_stop(1'b0, "R7");

        // protected upper quarter, then a second stop
        wp = 1'b1;
        t_load(12'hC40);
        for (int i = 0; i < 3; i++) t_byte(8'(8'hC0 + i), "R3");
        t_stop(1'b0, "R8");
        t_stop(1'b0, "R8");

        // protection on, lower page still written
        t_load(12'hBE0);
        for (int i = 0; i < 4; i++) t_byte(8'(8'h90 + i), "R3");
        t_stop(1'b0, "R11");

        // protection off, upper quarter written, wraps inside last page
        wp = 1'b0;
        t_load(12'hFFE);
        for (int i = 0; i < 4; i++) t_byte(8'(8'h70 + i), "R3");
        t_stop(1'b0, "R9");

        // inputs during busy are ignored
        t_load(12'h400);
        for (int i = 0; i < 5; i++) t_byte(8'(8'h10 + i), "R3");
        t_stop(1'b1, "R10");
        t_stop(1'b0, "R10");

        // random transfers
        for (int k = 0; k < 40; k++) begin
            logic [11:0] a;
            int nb;
            bit pk;
            wp = 1'($urandom);
            a  = 12'($urandom);
            if ($urandom % 2 == 0) a[11:10] = 2'b11;
            nb = int'($urandom % 41);
            pk = 1'($urandom);
            t_load(a);
            for (int j = 0; j < nb; j++) t_byte(8'($urandom), "R3");
            t_stop(pk, "R5");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule